// File: doc/BRIEF.md
# Two-Phase Register Access SPI Host

This block is the host side of a serial link to an actuator driver whose registers are reached through a two-phase access. Each access starts with a command byte, sent while a separate command-select pin is high. The byte that comes back during the command phase is the peripheral's fault flag byte. The host then releases chip select for one full serial clock period and lowers the command-select pin. It selects the peripheral again and moves either one data byte or a whole 32-bit word. A request carries direction, a 4-bit bank address, an 8-bit/32-bit mode flag and write data, and is taken on a valid/ready handshake. The results are the fault byte with its own strobe, and at the end the read data with a completion strobe.

The serial clock is made from the system clock by a half-period counter `HALF_DIV`. An elaboration-time check refuses any setting whose serial clock would exceed 10 MHz, or 5 MHz when `CHAINED` is set. The link runs in SPI mode 0: the clock idles low, MISO is sampled on the rising edge, MOSI changes on the falling edge, and bits go most significant first.

The controller is a four-state machine:
- IDLE: ready is high.
- CMD: command byte on the wire, command-select high.
- GAP: chip select high for two half periods.
- DATA: data bits on the wire, command-select low.

Transitions:
- IDLE→CMD: a valid request with bank ≤ 10 is accepted.
- IDLE→IDLE: a request with bank > 10 is accepted and rejected, and the error strobe pulses.
- CMD→GAP: the command byte's last falling edge is done, and the fault byte is latched.
- GAP→DATA: the second half-period tick arrives.
- DATA→IDLE: the last data bit is done.

Top module: `actu_spi_host`

## Requirements
- R1: The command byte is `{write, 2'b00, bank[3:0], mode8}` (write=1 for a write, mode8=1 for single-byte access). It is sent MSB first as exactly 8 serial clocks while `cmd_sel` is high.
- R2: The 8 bits sampled on MISO during the command phase appear on `fault_byte`, and `fault_valid` pulses for one cycle.
- R3: Between the command and data phases, `cs_n` stays high for at least one serial clock period (2·HALF_DIV system cycles). `cmd_sel` is low throughout the data phase.
- R4: The data phase is 8 serial clocks when mode8=1 and 32 otherwise. A write sends `wr_data[31:24]` in 8-bit mode and all of `wr_data` in 32-bit mode, MSB first.
- R5: A 32-bit read returns the 32 bits sampled in the data phase on `rd_data`, first bit in bit 31.
- R6: An 8-bit read returns the sampled byte in `rd_data[31:24]` with bits 23:0 zero.
- R7: A request with bank > 10 (0xA) is accepted, `req_err` pulses for one cycle, and no chip select or serial clock activity follows.
- R8: `sclk` idles low, is low whenever `cs_n` is high, and its rising edges within a phase are exactly 2·HALF_DIV system cycles apart.
- R9: `req_ready` is low from acceptance until completion. `done` pulses for one cycle at the end of an access. A write leaves `rd_data` unchanged.
- R10: After reset, `cs_n`=1, `sclk`=0, `cmd_sel`=0, `req_ready`=1, and `done`, `fault_valid` and `req_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_bank | input | 4 | Register bank address |
| req_mode8 | input | 1 | 1 = single MSB byte, 0 = full 32-bit word |
| wr_data | input | 32 | Write data (bits 31:24 in 8-bit mode) |
| rd_data | output | 32 | Read result |
| done | output | 1 | One-cycle strobe at end of access |
| fault_byte | output | 8 | Byte returned during the command phase |
| fault_valid | output | 1 | One-cycle strobe when fault_byte updates |
| req_err | output | 1 | One-cycle strobe for a rejected bank address |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |
| cs_n | output | 1 | Active-low chip select |
| cmd_sel | output | 1 | High during command phase, low during data phase |

## Verification
A state machine stuck in or skipping a state shows at the pins within one access. A skipped GAP shortens the `cs_n` high time measured between phases. A wrong bit counter changes the number of rising `sclk` edges that the bench peripheral model counts in each phase. A misrouted capture register corrupts `fault_byte` or `rd_data` at the very next strobe. A lost return to IDLE shows as `req_ready` staying low, which the completion wait catches within a few thousand cycles.

// File: rtl/actu_spi_pkg.sv
package actu_spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_GAP  = 2'd2,
        ST_DATA = 2'd3
    } host_state_t;

    localparam logic [3:0] BANK_LAST = 4'hA;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;

    function automatic logic [7:0] make_cmd(input logic wr, input logic [3:0] bank,
                                            input logic mode8);
        return {wr, 2'b00, bank, mode8};
    endfunction

endpackage

// File: rtl/actu_sclk_div.sv
module actu_sclk_div #(
    parameter int unsigned HALF_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/actu_shift_eng.sv
module actu_shift_eng #(
    parameter int unsigned W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(W+1)-1:0]   nbits,
    input  logic [W-1:0]             tx,
    input  logic                     tick,
    input  logic                     miso,
    output logic                     busy,
    output logic                     sclk,
    output logic                     mosi,
    output logic                     done,
    output logic [W-1:0]             rx
);
    localparam int unsigned CNTW = $clog2(W + 1);

    logic [W-1:0]    sr_q;
    logic [CNTW-1:0] left_q;

    assign mosi = sr_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            sclk   <= 1'b0;
            sr_q   <= '0;
            rx     <= '0;
            left_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                sclk   <= 1'b0;
                sr_q   <= tx;
                left_q <= nbits;
                rx     <= '0;
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (left_q == CNTW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        left_q <= left_q - 1'b1;
                        sr_q   <= {sr_q[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R8
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R4
    bit_left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left_q != '0 && left_q <= CNTW'(W)));

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/actu_spi_host.sv
module actu_spi_host
    import actu_spi_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 250_000_000,
    parameter int unsigned HALF_DIV = 13,
    parameter bit          CHAINED  = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [3:0]  req_bank,
    input  logic        req_mode8,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        done,
    output logic [7:0]  fault_byte,
    output logic        fault_valid,
    output logic        req_err,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic        cmd_sel
);
    localparam int unsigned SCLK_LIMIT = CHAINED ? 5_000_000 : 10_000_000;
    localparam int unsigned CNTW       = $clog2(WORD_W + 1);

    if (longint'(CLK_HZ) > longint'(SCLK_LIMIT) * 2 * longint'(HALF_DIV)) begin : g_sclk_too_fast
        $error("actu_spi_host: HALF_DIV too small, serial clock above limit");
    end

    host_state_t state_q, state_d;
    logic        write_q, mode8_q;
    logic [31:0] wdata_q;
    logic        gap_half_q;

    logic        tick, eng_busy, eng_done, eng_start, eng_sclk;
    logic [CNTW-1:0]   eng_nbits;
    logic [WORD_W-1:0] eng_tx, eng_rx;

    logic take, bank_ok;

    assign req_ready = (state_q == ST_IDLE);
    assign take      = req_valid && req_ready;
    assign bank_ok   = (req_bank <= BANK_LAST);

    actu_sclk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_busy || (state_q == ST_GAP)),
        .tick  (tick)
    );

    always_comb begin
        eng_start = 1'b0;
        eng_nbits = CNTW'(BYTE_W);
        eng_tx    = wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                eng_start = take && bank_ok;
                eng_tx    = {make_cmd(req_write, req_bank, req_mode8), 24'h0};
            end
            ST_GAP: begin
                eng_start = tick && gap_half_q;
                eng_nbits = mode8_q ? CNTW'(BYTE_W) : CNTW'(WORD_W);
            end
            ST_CMD, ST_DATA: begin
                eng_start = 1'b0;
            end
        endcase
    end

    actu_shift_eng #(.W(WORD_W)) eng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .nbits (eng_nbits),
        .tx    (eng_tx),
        .tick  (tick),
        .miso  (miso),
        .busy  (eng_busy),
        .sclk  (eng_sclk),
        .mosi  (mosi),
        .done  (eng_done),
        .rx    (eng_rx)
    );

    assign sclk = eng_sclk;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take && bank_ok)          state_d = ST_CMD;
            ST_CMD:  if (eng_done)                 state_d = ST_GAP;
            ST_GAP:  if (tick && gap_half_q)       state_d = ST_DATA;
            ST_DATA: if (eng_done)                 state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            write_q    <= 1'b0;
            mode8_q    <= 1'b0;
            wdata_q    <= '0;
            gap_half_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take && bank_ok) begin
                write_q <= req_write;
                mode8_q <= req_mode8;
                wdata_q <= wr_data;
            end
            if (state_q != ST_GAP) begin
                gap_half_q <= 1'b0;
            end else if (tick) begin
                gap_half_q <= 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n        <= 1'b1;
            cmd_sel     <= 1'b0;
            fault_byte  <= '0;
            fault_valid <= 1'b0;
            rd_data     <= '0;
            done        <= 1'b0;
            req_err     <= 1'b0;
        end else begin
            cs_n        <= !((state_d == ST_CMD) || (state_d == ST_DATA));
            cmd_sel     <= (state_d == ST_CMD);
            fault_valid <= 1'b0;
            done        <= 1'b0;
            req_err     <= take && !bank_ok;
            if (state_q == ST_CMD && eng_done) begin
                fault_byte  <= eng_rx[7:0];
                fault_valid <= 1'b1;
            end
            if (state_q == ST_DATA && eng_done) begin
                done <= 1'b1;
                if (!write_q) begin
                    rd_data <= mode8_q ? {eng_rx[7:0], 24'h0} : eng_rx;
                end
            end
        end
    end

    // R8
    sclk_low_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R7
    bad_bank_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bank_ok) |=> (req_err && cs_n && state_q == ST_IDLE));

    // R3
    data_cmd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> !cmd_sel);

    // R3
    gap_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (cs_n && !eng_busy));

    // R9
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault_valid, req_err}));

    // R2
    fault_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (state_q == ST_GAP));

endmodule

// File: tb/actu_spi_host_tb_top.sv
`timescale 1ns/1ps
module actu_spi_host_tb_top;
    localparam int unsigned HALF_DIV = 13;
    localparam time PER_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [3:0]  req_bank = 4'h0;
    logic        req_mode8 = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        done;
    logic [7:0]  fault_byte;
    logic        fault_valid;
    logic        req_err;
    logic        sclk, mosi, cs_n, cmd_sel;
    logic        miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    actu_spi_host #(.CLK_HZ(250_000_000), .HALF_DIV(HALF_DIV), .CHAINED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_mode8(req_mode8),
        .wr_data(wr_data), .rd_data(rd_data), .done(done), .fault_byte(fault_byte),
        .fault_valid(fault_valid), .req_err(req_err), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .cmd_sel(cmd_sel)
    );

    // peripheral model
    bit          armed = 1'b0;
    bit          next_is_cmd = 1'b1;
    bit          cur_is_cmd = 1'b0;
    bit          first_rise = 1'b0;
    logic [7:0]  fault_resp = '0;
    logic [31:0] data_resp = '0;
    logic [31:0] s_tx = '0, s_rx = '0;
    int          s_bits = 0;
    logic [7:0]  got_cmd = '0;
    int          got_cmd_bits = 0;
    logic        cmd_lvl_cmd = 1'b0, cmd_lvl_data = 1'b1;
    logic [31:0] got_data = '0;
    int          got_data_bits = 0;
    time         t_cs_rise = 0, gap_ns = 0, last_rise = 0;
    int          period_bad = 0;
    int          sclk_edges = 0;

    always @(negedge cs_n) if (armed) begin
        cur_is_cmd = next_is_cmd;
        next_is_cmd = !next_is_cmd;
        if (!cur_is_cmd) gap_ns = $time - t_cs_rise;
        s_tx = cur_is_cmd ? {fault_resp, 24'h0} : data_resp;
        miso = s_tx[31];
        s_rx = '0;
        s_bits = 0;
        first_rise = 1'b1;
    end

    always @(posedge sclk) if (armed) begin
        sclk_edges++;
        if (!first_rise && ($time - last_rise) != 2 * HALF_DIV * PER_NS) period_bad++;
        if (first_rise) begin
            if (cur_is_cmd) cmd_lvl_cmd = cmd_sel; else cmd_lvl_data = cmd_sel;
        end
        first_rise = 1'b0;
        last_rise = $time;
        s_rx = {s_rx[30:0], mosi};
        s_bits++;
    end

    always @(negedge sclk) if (armed) begin
        s_tx = {s_tx[30:0], 1'b0};
        miso = s_tx[31];
    end

    always @(posedge cs_n) if (armed) begin
        t_cs_rise = $time;
        if (cur_is_cmd) begin
            got_cmd = s_rx[7:0];
            got_cmd_bits = s_bits;
        end else begin
            got_data = s_rx;
            got_data_bits = s_bits;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input int b, input int w, input int m);
        logic [31:0] wd, prev_rd, exp_rd, exp_tx;
        logic [7:0]  exp_cmd;
        bit          fv_seen, hung;
        logic [7:0]  fv_val;
        int          edges0;
        wd         = 32'h5A3C_0000 + 32'(b) * 32'h0101_0307 + 32'(w) * 32'h0080_0000 + 32'(m);
        fault_resp = 8'(b * 17 + w * 3 + m * 5 + 1);
        data_resp  = 32'hC3A5_0F11 ^ (32'(b) * 32'h1111_0101) ^ {31'h0, w[0]};
        exp_cmd    = {w[0], 2'b00, 4'(b), m[0]};
        next_is_cmd = 1'b1;
        got_cmd_bits = 0;
        got_data_bits = 0;
        period_bad = 0;
        prev_rd = rd_data;
        edges0 = sclk_edges;
        @(negedge clk);
        req_valid = 1'b1; req_write = w[0]; req_bank = 4'(b); req_mode8 = m[0]; wr_data = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (b > 10) begin
            // R7: rejected bank
            chk(req_err === 1'b1, "R7 err strobe", {31'h0, req_err}, 32'h1);
            @(negedge clk);
            chk(req_err === 1'b0, "R7 err one cycle", {31'h0, req_err}, 32'h0);
            repeat (80) @(negedge clk);
            chk(cs_n === 1'b1 && sclk_edges == edges0 && req_ready === 1'b1,
                "R7 no bus activity", 32'(sclk_edges - edges0), 32'h0);
            return;
        end
        // R9: busy
        chk(req_ready === 1'b0, "R9 ready low while busy", {31'h0, req_ready}, 32'h0);
        fv_seen = 1'b0; fv_val = '0; hung = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (fault_valid) begin fv_seen = 1'b1; fv_val = fault_byte; end
            if (done) begin hung = 1'b0; break; end
        end
        chk(!hung, "R9 done strobe", {31'h0, hung}, 32'h0);
        // R1
        chk(got_cmd == exp_cmd && got_cmd_bits == 8, "R1 command byte", {24'h0, got_cmd},
            {24'h0, exp_cmd});
        chk(cmd_lvl_cmd === 1'b1, "R1 cmd_sel high in command", {31'h0, cmd_lvl_cmd}, 32'h1);
        // R2
        chk(fv_seen && fv_val == fault_resp, "R2 fault byte", {24'h0, fv_val},
            {24'h0, fault_resp});
        // R3
        chk(gap_ns >= 2 * HALF_DIV * PER_NS, "R3 deselect gap", 32'(gap_ns),
            32'(2 * HALF_DIV * PER_NS));
        chk(cmd_lvl_data === 1'b0, "R3 cmd_sel low in data", {31'h0, cmd_lvl_data}, 32'h0);
        // R4
        chk(got_data_bits == (m ? 8 : 32), "R4 data length", 32'(got_data_bits),
            m ? 32'd8 : 32'd32);
        if (w) begin
            exp_tx = m ? {24'h0, wd[31:24]} : wd;
            chk(got_data == exp_tx, "R4 write data", got_data, exp_tx);
            chk(rd_data == prev_rd, "R9 write keeps rd_data", rd_data, prev_rd);
        end else if (m) begin
            exp_rd = {data_resp[31:24], 24'h0};
            chk(rd_data == exp_rd, "R6 byte read placement", rd_data, exp_rd);
        end else begin
            chk(rd_data == data_resp, "R5 word read", rd_data, data_resp);
        end
        // R8
        chk(period_bad == 0, "R8 sclk period", 32'(period_bad), 32'h0);
        @(negedge clk);
        chk(done === 1'b0 && req_ready === 1'b1 && cs_n === 1'b1 && sclk === 1'b0,
            "R9 done one cycle and idle", {28'h0, done, req_ready, cs_n, sclk}, 32'h6);
    endtask

    initial begin : watchdog
        repeat (200_000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(cs_n === 1'b1 && sclk === 1'b0 && cmd_sel === 1'b0 && req_ready === 1'b1,
            "R10 reset pins", {28'h0, cs_n, sclk, cmd_sel, req_ready}, 32'h9);
        chk(done === 1'b0 && fault_valid === 1'b0 && req_err === 1'b0,
            "R10 reset strobes", {29'h0, done, fault_valid, req_err}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        armed = 1'b1;
        for (int b = 0; b < 16; b++)
            for (int w = 0; w < 2; w++)
                for (int m = 0; m < 2; m++)
                    run_op(b, w, m);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule